// File: doc/BRIEF.md
# Asynchronous SRAM port controller

This block lets a clocked host read and write an external asynchronous static RAM of up to 128K bytes. The host issues one request at a time over a valid/ready handshake: an address, a write flag and a write byte. For a read, it gets the byte back together with a strobe that is high for one cycle. On the memory side the block drives active-low chip select, output enable and write enable, the address, and a bidirectional data bus. The bus is split into an outgoing byte, an output-enable and an incoming byte.

Every memory access is a fixed number of clock cycles. These counts are derived at elaboration time from nanosecond limits and the clock period: each limit is divided by the period, rounded up and held to at least one cycle. Writes are controlled by write enable, and output enable stays high throughout a write. After a read, the controller waits out the memory's bus-release time before it accepts anything else, so the two drivers never overlap on the bus.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, chip select, output enable and write enable are all high (inactive) and the controller does not drive the data bus. During reset and when idle, reqReady is 1 and rspValid is 0.
- R2: An accepted write (reqWrite=1) drives chip select and write enable low together for exactly WR_CYC cycles, with output enable held high. WR_CYC is the largest of ceil(ns/CLK_NS) over the write-pulse, data-setup, address-setup and write-cycle limits, each at least 1. Address and write byte are driven and stable for the whole interval, and the bus is driven throughout it.
- R3: An accepted read (reqWrite=0) drives chip select and output enable low with write enable high for exactly RD_CYC cycles, with the address stable. RD_CYC is the larger of ceil(address-access ns/CLK_NS) and ceil(output-enable-access ns/CLK_NS).
- R4: The read byte is sampled from memDqIn on the clock edge that ends the read. It appears on rspRdata with rspValid high for exactly one cycle, starting RD_CYC edges after the accepting edge. rspRdata then holds until the next read completes, and writes give no rspValid.
- R5: After a read, output enable stays high for TURN_CYC = ceil(bus-release ns/CLK_NS) cycles, at least 1, before the block can accept again. The controller never drives the bus while output enable is low, nor within that window.
- R6: A request is taken on a rising edge where reqValid and reqReady are both 1. reqReady is low from that edge until the access ends. Request inputs presented while reqReady is low have no effect on the access in progress or on memory contents.
- R7: A write keeps reqReady low for WR_CYC cycles. A read keeps it low for RD_CYC+TURN_CYC cycles.
- R8: Every byte written to an address is the byte later read back from it, for every address and in any order of reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can take a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Byte to write |
| rspValid | output | 1 | One-cycle strobe: rspRdata holds new read data |
| rspRdata | output | DATA_W | Last byte read |
| memCeN | output | 1 | Memory chip select, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memAddr | output | ADDR_W | Memory address |
| memDqOut | output | DATA_W | Byte driven onto the memory bus |
| memDqOe | output | 1 | Controller drives the memory bus when 1 |
| memDqIn | input | DATA_W | Byte seen on the memory bus |

## Verification
The bench runs the controller at slower timing limits, so each count spans several cycles. It sweeps every address of a small memory through write, read, interleaved read-after-write and reversed-order passes. Its memory model returns a bit-inverted byte until the access time has truly elapsed, so a controller that samples even one edge early reads wrong data. The model also reports a write pulse shorter than any limit, an address or data change mid-pulse, and any cycle in which the controller drives while the memory may still be driving; a skipped turnaround shows up as contention on the next write. The bench also scrambles the request inputs while the controller is busy, so a controller that latches them late corrupts memory contents.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic loadReq;   // latch host address and write byte
    logic driveOn;   // start driving the memory bus
    logic driveOff;  // stop driving the memory bus
    logic capture;   // sample the memory bus into the read register
  } dpStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_TURN  = 2'd3
  } ctrlState_t;

  // ceil(ns / clkNs), never below one cycle
  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_port_dp.sv
module sram_port_dp
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rspRdata
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
      memDqOe  <= 1'b0;
      rspRdata <= '0;
    end else begin
      if (stb.loadReq) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWdata;
      end
      if (stb.driveOn)       memDqOe <= 1'b1;
      else if (stb.driveOff) memDqOe <= 1'b0;
      if (stb.capture)       rspRdata <= memDqIn;
    end
  end

  // R2: the write byte does not move while it is on the bus
  a_r2_wdata_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe && $past(memDqOe)) |-> $stable(memDqOut));

endmodule

// File: rtl/sram_port_fsm.sv
module sram_port_fsm
  import sram_port_pkg::*;
#(
  parameter int WR_CYC   = 1,
  parameter int RD_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       rspValid,
  output logic       memCeN,
  output logic       memOeN,
  output logic       memWeN,
  output dpStrobes_t stb
);

  localparam int MAX_CYC = maxOf(maxOf(WR_CYC, RD_CYC), TURN_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

  ctrlState_t       state;
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;

  always_comb begin
    stb          = '0;
    stb.loadReq  = accept;
    stb.driveOn  = accept && reqWrite;
    stb.driveOff = (state == ST_WRITE) && (cnt == WR_LAST);
    stb.capture  = (state == ST_READ) && (cnt == RD_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      memCeN   <= 1'b1;
      memOeN   <= 1'b1;
      memWeN   <= 1'b1;
      rspValid <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cnt    <= '0;
            memCeN <= 1'b0;
            if (reqWrite) begin
              memWeN <= 1'b0;
              state  <= ST_WRITE;
            end else begin
              memOeN <= 1'b0;
              state  <= ST_READ;
            end
          end
        end
        ST_WRITE: begin
          if (cnt == WR_LAST) begin
            memCeN <= 1'b1;
            memWeN <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_READ: begin
          if (cnt == RD_LAST) begin
            memCeN   <= 1'b1;
            memOeN   <= 1'b1;
            rspValid <= 1'b1;
            cnt      <= '0;
            state    <= ST_TURN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TURN: begin
          if (cnt == TURN_LAST) state <= ST_IDLE;
          else                  cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: idle means every memory strobe inactive
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (memCeN && memOeN && memWeN));

  // R2: write enable low only with chip select low and output enable high
  a_r2_write_encoding: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCeN));

  // R3: output enable low only with chip select low and write enable high
  a_r3_read_encoding: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCeN));

  // R4: read strobe lasts one cycle
  a_r4_rsp_single: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R6: an accepted request drops ready on the next cycle
  a_r6_one_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8,
  parameter int CLK_NS         = 10,
  parameter int WR_PULSE_NS    = 7,
  parameter int WR_CYCLE_NS    = 10,
  parameter int DATA_SETUP_NS  = 5,
  parameter int ADDR_SETUP_NS  = 8,
  parameter int ADDR_ACCESS_NS = 10,
  parameter int OE_ACCESS_NS   = 5,
  parameter int BUS_RELEASE_NS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int WR_CYC = maxOf(
    maxOf(nsToCycles(WR_PULSE_NS, CLK_NS), nsToCycles(DATA_SETUP_NS, CLK_NS)),
    maxOf(nsToCycles(ADDR_SETUP_NS, CLK_NS), nsToCycles(WR_CYCLE_NS, CLK_NS)));
  localparam int RD_CYC = maxOf(nsToCycles(ADDR_ACCESS_NS, CLK_NS),
                                nsToCycles(OE_ACCESS_NS, CLK_NS));
  localparam int TURN_CYC = nsToCycles(BUS_RELEASE_NS, CLK_NS);

  dpStrobes_t stb;

  sram_port_fsm #(
    .WR_CYC  (WR_CYC),
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .rspValid(rspValid),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .stb     (stb)
  );

  sram_port_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .rspRdata(rspRdata)
  );

  // Run-length counters for the timing assertions below
  localparam logic [15:0] WR_RUN   = 16'(WR_CYC);
  localparam logic [15:0] RD_RUN   = 16'(RD_CYC);
  localparam logic [15:0] TURN_SAT = 16'(TURN_CYC + 1);

  logic [15:0] weRun, oeRun, oeHighRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weRun     <= '0;
      oeRun     <= '0;
      oeHighRun <= TURN_SAT;
    end else begin
      weRun <= memWeN ? 16'd0 : weRun + 16'd1;
      oeRun <= memOeN ? 16'd0 : oeRun + 16'd1;
      if (!memOeN)                oeHighRun <= '0;
      else if (oeHighRun < TURN_SAT) oeHighRun <= oeHighRun + 16'd1;
    end
  end

  // R2: write pulse is exactly WR_CYC cycles
  a_r2_we_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weRun == WR_RUN));

  // R3: read strobe is exactly RD_CYC cycles
  a_r3_oe_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeRun == RD_RUN));

  // R3: address holds while the memory is selected
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R5: no drive while output enable is low
  a_r5_no_drive_oe_low: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  // R5: drive starts only after the release window
  a_r5_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> (oeHighRun >= TURN_SAT));

  // R2: bus driven exactly while write enable is low
  a_r2_drive_matches_we: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe == !memWeN);

endmodule

// File: tb/sram_port_ctrl_tb.sv
module sram_port_ctrl_tb;

  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int T_NS  = 10;
  localparam int WP_NS = 18;
  localparam int WC_NS = 20;
  localparam int DS_NS = 15;
  localparam int AS_NS = 22;
  localparam int AA_NS = 27;
  localparam int OA_NS = 12;
  localparam int BR_NS = 14;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + T_NS - 1) / T_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WR_EXP   = mx(mx(cdiv(WP_NS), cdiv(DS_NS)), mx(cdiv(AS_NS), cdiv(WC_NS)));
  localparam int RD_EXP   = mx(cdiv(AA_NS), cdiv(OA_NS));
  localparam int TURN_EXP = cdiv(BR_NS);
  localparam int HZ_CYC   = cdiv(BR_NS);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          rspValid;
  logic [DW-1:0] rspRdata;
  logic          memCeN, memOeN, memWeN;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDqOut;
  logic          memDqOe;
  logic [DW-1:0] memDqIn;

  always #5 clk = ~clk;

  sram_port_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_NS(T_NS),
    .WR_PULSE_NS(WP_NS), .WR_CYCLE_NS(WC_NS), .DATA_SETUP_NS(DS_NS),
    .ADDR_SETUP_NS(AS_NS), .ADDR_ACCESS_NS(AA_NS), .OE_ACCESS_NS(OA_NS),
    .BUS_RELEASE_NS(BR_NS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [DW-1:0] mem [DEPTH];
  int            rdAge = 0;
  int            tail  = 0;
  int            wrAge = 0;
  logic [AW-1:0] lastAddr = '0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic          readCond, writeCond, dataValid;

  assign readCond  = !memCeN && !memOeN && memWeN;
  assign writeCond = !memCeN && !memWeN;
  assign dataValid = readCond && ((rdAge + 1) * T_NS >= AA_NS) && ((rdAge + 1) * T_NS >= OA_NS);
  // Bit-inverted until the access time has elapsed
  assign memDqIn   = dataValid ? mem[memAddr] : ~mem[memAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      rdAge <= 0;
      tail  <= 0;
      wrAge <= 0;
    end else begin
      rdAge    <= readCond ? ((rdAge != 0 && memAddr == lastAddr) ? rdAge + 1 : 1) : 0;
      lastAddr <= memAddr;
      tail     <= readCond ? HZ_CYC : ((tail > 0) ? tail - 1 : 0);
      if (memDqOe && (readCond || tail > 0))
        check(1'b0, "R5 bus contention (memDqOe)", 1, 0);
      if (writeCond) begin
        if (!memDqOe) check(1'b0, "R2 bus not driven in write", 0, 1);
        if (wrAge == 0) begin
          wrAddr <= memAddr;
          wrData <= memDqOut;
        end else if (memAddr != wrAddr || memDqOut != wrData) begin
          check(1'b0, "R2 addr/data moved in write pulse", int'(memDqOut), int'(wrData));
        end
        wrAge <= wrAge + 1;
      end else if (wrAge > 0) begin
        if (wrAge * T_NS < WP_NS || wrAge * T_NS < DS_NS ||
            wrAge * T_NS < AS_NS || wrAge * T_NS < WC_NS)
          check(1'b0, "R2 write pulse too short (ns)", wrAge * T_NS, WR_EXP * T_NS);
        mem[wrAddr] <= wrData;
        wrAge <= 0;
      end
    end
  end

  // ---------------- strobe width monitor ----------------
  int weRunTb = 0;
  int oeRunTb = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (!memWeN) weRunTb++;
      else if (weRunTb > 0) begin
        check(weRunTb == WR_EXP, "R2 write enable low width", weRunTb, WR_EXP);
        weRunTb = 0;
      end
      if (!memOeN) begin
        oeRunTb++;
        if (!memWeN) check(1'b0, "R3 write enable low during read", 0, 1);
      end else if (oeRunTb > 0) begin
        check(oeRunTb == RD_EXP, "R3 output enable low width", oeRunTb, RD_EXP);
        oeRunTb = 0;
      end
    end
  end

  // ---------------- host driver ----------------
  task automatic doAccess(input bit wr, input int addr, input int data,
                          output int busy, output int rspIdx, output int rspCnt,
                          output int rd);
    int idx;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = AW'(addr);
    reqWdata = DW'(data);
    @(negedge clk);
    // R6: scramble inputs while busy; they must be ignored
    reqValid = 1'b0;
    reqWrite = !wr;
    reqAddr  = ~AW'(addr);
    reqWdata = ~DW'(data);
    busy = 0; rspIdx = 0; rspCnt = 0; rd = 0; idx = 1;
    while (!reqReady) begin
      if (rspValid) begin rspIdx = idx; rspCnt++; rd = int'(rspRdata); end
      busy++;
      idx++;
      @(negedge clk);
      reqAddr  = reqAddr + AW'(idx);
      reqWdata = reqWdata ^ DW'(8'h5A);
    end
    if (rspValid) begin rspIdx = idx; rspCnt++; rd = int'(rspRdata); end
  endtask

  function automatic int pat1(input int a);
    return (a * 37 + 11) & 8'hFF;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int busy, rIdx, rCnt, rd, held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(memCeN && memOeN && memWeN, "R1 strobes high in reset", int'({memCeN, memOeN, memWeN}), 7);
    check(!memDqOe, "R1 bus released in reset", int'(memDqOe), 0);
    check(reqReady, "R1 ready in reset", int'(reqReady), 1);
    check(!rspValid, "R1 no response in reset", int'(rspValid), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(memCeN && memOeN && memWeN && !memDqOe, "R1 idle after reset",
          int'({memCeN, memOeN, memWeN, memDqOe}), 14);

    // Sweep 1: write every address (R7, R6)
    for (int a = 0; a < DEPTH; a++) begin
      doAccess(1'b1, a, pat1(a), busy, rIdx, rCnt, rd);
      check(busy == WR_EXP, "R7 write busy cycles", busy, WR_EXP);
      check(rCnt == 0, "R4 no response on write", rCnt, 0);
    end
    // Read every address ascending (R3, R4, R5, R8)
    for (int a = 0; a < DEPTH; a++) begin
      doAccess(1'b0, a, 0, busy, rIdx, rCnt, rd);
      check(rd == pat1(a), "R8 read-back sweep 1", rd, pat1(a));
      check(rIdx == RD_EXP + 1, "R4 response timing", rIdx, RD_EXP + 1);
      check(rCnt == 1, "R4 single response", rCnt, 1);
      check(busy == RD_EXP + TURN_EXP, "R5 read busy incl turnaround", busy, RD_EXP + TURN_EXP);
    end
    // Sweep 2 descending: write then read at once (R5 write-after-read, R8)
    for (int a = DEPTH - 1; a >= 0; a--) begin
      doAccess(1'b1, a, ~pat1(a) & 8'hFF, busy, rIdx, rCnt, rd);
      doAccess(1'b0, a, 0, busy, rIdx, rCnt, rd);
      check(rd == (~pat1(a) & 8'hFF), "R8 read-after-write", rd, ~pat1(a) & 8'hFF);
    end
    // Read back sweep 2 in a strided order (R8)
    for (int k = 0; k < DEPTH; k++) begin
      int a;
      a = (k * 5 + 3) % DEPTH;
      doAccess(1'b0, a, 0, busy, rIdx, rCnt, rd);
      check(rd == (~pat1(a) & 8'hFF), "R8 strided read-back", rd, ~pat1(a) & 8'hFF);
    end
    // R4: read data holds across a later write
    doAccess(1'b0, 9, 0, busy, rIdx, rCnt, rd);
    held = rd;
    doAccess(1'b1, 10, 8'hC3, busy, rIdx, rCnt, rd);
    @(negedge clk);
    check(int'(rspRdata) == held, "R4 rspRdata holds after write", int'(rspRdata), held);
    doAccess(1'b0, 10, 0, busy, rIdx, rCnt, rd);
    check(rd == 8'hC3, "R8 single overwrite", rd, 8'hC3);

    // R1: idle at end
    repeat (4) @(negedge clk);
    check(memCeN && memOeN && memWeN && !memDqOe && reqReady && !rspValid,
          "R1 idle at end", int'({memCeN, memOeN, memWeN, memDqOe}), 14);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule